// File: doc/BRIEF.md
# Text and Block-Graphics Dot Serializer

This block turns one latched character byte into the six serial dots of one character cell on a raster display. The top bit of the byte chooses between a text cell and a block-graphics cell. For text, the block passes the character code to an external glyph table (with an optional case fold that maps lowercase codes onto their uppercase glyphs) and takes back a 5-dot row pattern, which it places in the five leftmost dots. The sixth dot stays dark as the gap between characters. For graphics, the 6x12 cell is split into six 3-dot by 4-row rectangles. Each rectangle is lit by one bit of the byte.

A free-running dot counter raises a load strobe once every six dot clocks. In that cycle the cell inputs are sampled and the composed pattern is loaded into a shift register. The most significant dot is shifted out first, one dot per clock. Cells are forced dark when they are outside the visible area or when the current slot belongs to a CPU access. A full-screen inverse control complements every dot at the output.

Top module: `cell_dot_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `loadStrobe` is 1. While reset is held, `video` equals `inverse`.
- R2: `loadStrobe` is high for exactly one cycle in every 6.
- R3: The pattern loaded at a load edge appears on `video` from the next cycle on. The leftmost dot comes first, one dot per cycle, and the last dot is shown during the next load cycle.
- R4: A text cell (`charByte[7]`=0) in rows 0 to 6 shows `glyphRow[4]` down to `glyphRow[0]` as dots 1 to 5. Dot 6 is always dark.
- R5: A text cell in rows 7 to 15 is entirely dark, whatever `glyphRow` holds.
- R6: A graphics cell (`charByte[7]`=1) in band k = row/4 (k = 0, 1, 2 for rows 0 to 11) lights dots 1 to 3 with bit 2k and dots 4 to 6 with bit 2k+1.
- R7: A graphics cell in rows 12 to 15 is entirely dark.
- R8: `glyphCode` equals `charByte[6:0]`, except when `capsLock`=1, bit 7 is 0 and bits 6:5 are both 1. In that case bit 6 of `glyphCode` is 0.
- R9: A cell loaded while `inDisplay`=0 or `cpuSlot`=1 is entirely dark.
- R10: `video` is the composed dot XOR `inverse`, and this includes dark and suppressed cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low synchronous reset |
| charByte | input | 8 | Latched character byte; bit 7 selects graphics |
| scanRow | input | 4 | Scan row within the cell, 0 to 11 |
| glyphRow | input | 5 | Glyph row pattern for `glyphCode` and `scanRow`, MSB leftmost |
| capsLock | input | 1 | Fold lowercase codes to uppercase |
| inDisplay | input | 1 | Cell lies inside the visible area |
| cpuSlot | input | 1 | Current slot belongs to a CPU access |
| inverse | input | 1 | Full-screen inverse video |
| glyphCode | output | 7 | Character code sent to the glyph table |
| video | output | 1 | Serial dot output |
| loadStrobe | output | 1 | High in the cycle that samples the cell inputs |

## Verification
The checker monitors the following on every cycle:
- the six-cycle spacing of the load strobe;
- the dark sixth dot of text cells;
- the first dot after a load for suppressed cells, blanked text rows and graphics bands;
- the case-fold mapping on `glyphCode`.

The full dot vector of every cell can only be shown by the bench. It sweeps every byte value against every scan row, with case folding both on and off, and then adds suppressed and inverted cells. The exact ordering of the six dots and the per-dot effect of inversion are therefore covered by those scenarios.

// File: rtl/cell_dot_pkg.sv
`timescale 1ns/100ps
package cell_dot_pkg;
  localparam int CODE_W   = 8;
  localparam int MODE_BIT = 7;
  localparam int CASE_BIT = 6;

  typedef struct packed {
    logic load;
    logic shift;
  } dotCtl_t;
endpackage

// File: rtl/cell_dot_ctrl.sv
`timescale 1ns/100ps
module cell_dot_ctrl
  import cell_dot_pkg::*;
#(
  parameter int DOTS = 6
) (
  input  logic    clk,
  input  logic    rstN,
  output dotCtl_t ctl
);
  localparam int CNT_W = $clog2(DOTS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DOTS - 1);

  logic [CNT_W-1:0] dotCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dotCnt <= '0;
    end else if (dotCnt == LAST) begin
      dotCnt <= '0;
    end else begin
      dotCnt <= dotCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.load  = (dotCnt == '0);
    ctl.shift = (dotCnt != '0);
  end
endmodule

// File: rtl/cell_dot_path.sv
`timescale 1ns/100ps
module cell_dot_path
  import cell_dot_pkg::*;
#(
  parameter int DOTS       = 6,
  parameter int GLYPH_W    = 5,
  parameter int ROW_W      = 4,
  parameter int GLYPH_ROWS = 7,
  parameter int TEXT_ROWS  = 8,
  parameter int BAND_ROWS  = 4,
  parameter int BANDS      = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dotCtl_t             ctl,
  input  logic [CODE_W-1:0]   charByte,
  input  logic [ROW_W-1:0]    scanRow,
  input  logic [GLYPH_W-1:0]  glyphRow,
  input  logic                capsLock,
  input  logic                inDisplay,
  input  logic                cpuSlot,
  input  logic                inverse,
  output logic [CODE_W-2:0]   glyphCode,
  output logic                video
);
  localparam int HALF = DOTS / 2;
  localparam int PAD  = DOTS - GLYPH_W;

  logic            isGfx;
  logic            isLower;
  logic            visible;
  logic            textLive;
  logic [DOTS-1:0] textPat;
  logic [DOTS-1:0] gfxPat;
  logic [DOTS-1:0] cellPat;
  logic [DOTS-1:0] shiftReg;

  assign isGfx   = charByte[MODE_BIT];
  assign isLower = !isGfx && (charByte[CASE_BIT:CASE_BIT-1] == 2'b11);
  assign visible = inDisplay && !cpuSlot;

  always_comb begin
    glyphCode = charByte[CODE_W-2:0];
    if (capsLock && isLower) glyphCode[CASE_BIT] = 1'b0;
  end

  always_comb begin
    textLive = (int'(scanRow) < GLYPH_ROWS) && (int'(scanRow) < TEXT_ROWS);
    textPat  = textLive ? {glyphRow, {PAD{1'b0}}} : '0;
  end

  always_comb begin
    gfxPat = '0;
    for (int b = 0; b < BANDS; b++) begin
      if (int'(scanRow) / BAND_ROWS == b) begin
        gfxPat = {{HALF{charByte[2*b]}}, {(DOTS-HALF){charByte[2*b+1]}}};
      end
    end
  end

  always_comb begin
    if (!visible)   cellPat = '0;
    else if (isGfx) cellPat = gfxPat;
    else            cellPat = textPat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.load) begin
      shiftReg <= cellPat;
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[DOTS-2:0], 1'b0};
    end
  end

  assign video = shiftReg[DOTS-1] ^ inverse;
endmodule

// File: rtl/cell_dot_serializer.sv
`timescale 1ns/100ps
module cell_dot_serializer
  import cell_dot_pkg::*;
#(
  parameter int DOTS    = 6,
  parameter int GLYPH_W = 5,
  parameter int ROW_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         charByte,
  input  logic [ROW_W-1:0]   scanRow,
  input  logic [GLYPH_W-1:0] glyphRow,
  input  logic               capsLock,
  input  logic               inDisplay,
  input  logic               cpuSlot,
  input  logic               inverse,
  output logic [6:0]         glyphCode,
  output logic               video,
  output logic               loadStrobe
);
  dotCtl_t ctl;

  cell_dot_ctrl #(.DOTS(DOTS)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctl  (ctl)
  );

  cell_dot_path #(.DOTS(DOTS), .GLYPH_W(GLYPH_W), .ROW_W(ROW_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .charByte  (charByte),
    .scanRow   (scanRow),
    .glyphRow  (glyphRow),
    .capsLock  (capsLock),
    .inDisplay (inDisplay),
    .cpuSlot   (cpuSlot),
    .inverse   (inverse),
    .glyphCode (glyphCode),
    .video     (video)
  );

  assign loadStrobe = ctl.load;
endmodule

// File: rtl/cell_dot_checker.sv
`timescale 1ns/100ps
module cell_dot_checker #(
  parameter int DOTS  = 6,
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [7:0]       charByte,
  input logic [ROW_W-1:0] scanRow,
  input logic             capsLock,
  input logic             inDisplay,
  input logic             cpuSlot,
  input logic             inverse,
  input logic [6:0]       glyphCode,
  input logic             video,
  input logic             loadStrobe
);
  localparam int CW = $clog2(DOTS);
  localparam logic [CW-1:0] LASTC = CW'(DOTS - 1);

  logic [CW-1:0] sinceLoad;
  logic          prevText;
  logic          visible;
  logic          gfxLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceLoad <= LASTC;
      prevText  <= 1'b0;
    end else if (loadStrobe) begin
      sinceLoad <= '0;
      prevText  <= !charByte[7];
    end else begin
      sinceLoad <= sinceLoad + 1'b1;
    end
  end

  assign visible = inDisplay && !cpuSlot;

  always_comb begin
    case (int'(scanRow) / 4)
      0:       gfxLeft = charByte[0];
      1:       gfxLeft = charByte[2];
      2:       gfxLeft = charByte[4];
      default: gfxLeft = 1'b0;
    endcase
  end

  // R2
  a_r2_load_spacing: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> sinceLoad == LASTC);
  // R2
  a_r2_load_due: assert property (@(posedge clk) disable iff (!rstN)
    sinceLoad == LASTC |-> loadStrobe);
  // R4
  a_r4_sixth_dot_dark: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe && prevText |-> video == inverse);
  // R5
  a_r5_text_rows_dark: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe && !charByte[7] && int'(scanRow) >= 7 |=> video == inverse);
  // R6
  a_r6_gfx_first_dot: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe && charByte[7] && visible && int'(scanRow) < 12
    |=> video == ($past(gfxLeft) ^ inverse));
  // R9
  a_r9_suppressed_dark: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe && !visible |=> video == inverse);
  // R8
  a_r8_code_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !capsLock || charByte[7] |-> glyphCode == charByte[6:0]);
  // R8
  a_r8_caps_fold: assert property (@(posedge clk) disable iff (!rstN)
    capsLock && !charByte[7] && charByte[6:5] == 2'b11
    |-> !glyphCode[6] && glyphCode[5:0] == charByte[5:0]);
endmodule

bind cell_dot_serializer cell_dot_checker #(.DOTS(DOTS), .ROW_W(ROW_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .charByte   (charByte),
  .scanRow    (scanRow),
  .capsLock   (capsLock),
  .inDisplay  (inDisplay),
  .cpuSlot    (cpuSlot),
  .inverse    (inverse),
  .glyphCode  (glyphCode),
  .video      (video),
  .loadStrobe (loadStrobe)
);

// File: tb/sim_cell_dot_serializer.sv
`timescale 1ns/100ps
module sim_cell_dot_serializer;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] charByte;
  logic [3:0] scanRow;
  logic [4:0] glyphRow;
  logic       capsLock, inDisplay, cpuSlot, inverse;
  logic [6:0] glyphCode;
  logic       video, loadStrobe;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cell_dot_serializer u0 (
    .clk(clk), .rstN(rstN), .charByte(charByte), .scanRow(scanRow),
    .glyphRow(glyphRow), .capsLock(capsLock), .inDisplay(inDisplay),
    .cpuSlot(cpuSlot), .inverse(inverse), .glyphCode(glyphCode),
    .video(video), .loadStrobe(loadStrobe)
  );

  function automatic logic [4:0] glyphOf(logic [6:0] c, logic [3:0] r);
    int v;
    v = int'(c) * 11 + int'(r) * 7 + 3;
    return 5'(v ^ (int'(c) >> 3));
  endfunction

  function automatic logic [5:0] expPat(logic [7:0] b, logic [3:0] r,
                                        logic disp, logic cpu, logic [4:0] g);
    int band;
    logic l, rt;
    if (!disp || cpu) return 6'b0;
    if (b[7]) begin
      if (r >= 12) return 6'b0;
      band = int'(r) / 4;
      l  = b[band*2];
      rt = b[band*2+1];
      return {l, l, l, rt, rt, rt};
    end
    if (r >= 7) return 6'b0;
    return {g, 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Called at a negedge in a load cycle; returns at the negedge of the next load cycle.
  task automatic runCell(input logic [7:0] b, input logic [3:0] r, input logic caps,
                         input logic disp, input logic cpu, input logic inv,
                         input string tagIn);
    logic [6:0] ec;
    logic [5:0] ep, got;
    bit ldOk;
    string tag;
    charByte = b; scanRow = r; capsLock = caps;
    inDisplay = disp; cpuSlot = cpu; inverse = inv;
    ec = b[6:0];
    if (caps && !b[7] && b[6:5] == 2'b11) ec[6] = 1'b0;
    glyphRow = glyphOf(ec, r);
    #0.5;
    check(glyphCode == ec, "R8", "glyphCode", int'(glyphCode), int'(ec));
    ep = expPat(b, r, disp, cpu, glyphRow) ^ {6{inv}};
    if (tagIn != "") tag = tagIn;
    else if (!disp || cpu) tag = "R9";
    else if (b[7]) tag = (r >= 12) ? "R7" : "R6";
    else tag = (r >= 7) ? "R5" : "R4";
    @(posedge clk);
    ldOk = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      got[5-k] = video;
      if (loadStrobe != (k == 5)) ldOk = 1'b0;
    end
    check(got == ep, tag, "dots", int'(got), int'(ep));
    check(ldOk, "R2", "load spacing", int'(ldOk), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; charByte = 8'h00; scanRow = 4'd0; glyphRow = 5'd0;
    capsLock = 1'b0; inDisplay = 1'b1; cpuSlot = 1'b0; inverse = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(video == 1'b0, "R1", "video in reset", int'(video), 0);
    check(loadStrobe == 1'b1, "R1", "load in reset", int'(loadStrobe), 1);
    inverse = 1'b1;
    #0.5;
    check(video == 1'b1, "R1", "video in reset, inverse", int'(video), 1);
    inverse = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    check(loadStrobe == 1'b1, "R1", "first load", int'(loadStrobe), 1);

    // R3: graphics byte with bit0=1, bit1=0 gives 111000, then text order
    runCell(8'h85, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    runCell(8'h86, 4'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    runCell(8'h41, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R3");

    // Sweep every byte, every row, case folding off and on (R4..R8)
    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 256; b++)
        for (int r = 0; r < 16; r++)
          runCell(8'(b), 4'(r), 1'(c), 1'b1, 1'b0, 1'b0, "");

    // R9: suppression by display window and by CPU slot
    for (int b = 0; b < 256; b += 3) begin
      runCell(8'(b), 4'(b % 12), 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      runCell(8'(b), 4'(b % 12), 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    end

    // R10: inverse over live, blank and suppressed cells
    for (int b = 0; b < 256; b++)
      runCell(8'(b), 4'(b % 16), 1'(b[6]), 1'b1, 1'b0, 1'b1, "R10");
    runCell(8'hFF, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    runCell(8'h41, 4'd9, 1'b0, 1'b1, 1'b1, 1'b1, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule